// File: doc/BRIEF.md
# Dual-Level Interrupt Mask Controller

This block gathers up to 31 level-sensitive request lines from peripherals and external pins and sends each one to one of two processor request outputs: a normal interrupt, or a fast, high-priority interrupt. Software sees four registers per level: a read-only view of the raw request lines, an enable mask that can only be set, a write-one-to-clear companion that clears enable bits, and a read-only status view that is the raw lines masked by that level's enables.

A single source can never be enabled on both levels at once. Setting a bit in one level's enable mask also removes that bit from the other level's mask. A source may still be disabled on both. There is no priority encoder and no vector. Each request output is a plain OR of its level's status bits, and the interrupt handler reads the status register to find out which source is asking. Source lines pass through one register stage, and both request outputs are registered.

The register bus is a 3-bit word address, a write strobe, 32-bit write data and a combinational 32-bit read data port.

Top module: `dual_level_intc`

## Requirements
- R1: Address bit 2 selects the level (0 normal, 1 fast). Address bits 1:0 select the register: 0 raw, 1 enable, 2 clear, 3 status. Raw reads return the registered source lines on bits 30:0 and 0 on bit 31 at both level addresses. Writes to raw do not change it.
- R2: Writing an enable register sets every writable bit that is 1 in the write data. Bits written as 0 keep their value.
- R3: Writing a clear register clears every enable bit of that level that is 1 in the write data and leaves the other bits alone. A clear register always reads 0.
- R4: Setting an enable bit on one level clears the same bit on the other level, so the two enable masks never share a 1.
- R5: Bit 1 (the software-interrupt position) and bit 31 (reserved) of both enable masks stay 0 whatever is written.
- R6: Each level's status register equals raw AND that level's enable mask.
- R7: The normal request is the OR of all 32 normal status bits, registered. A source change reaches it after two rising edges, and an enable write reaches it one edge after the write is taken.
- R8: The fast request is the registered OR of fast status bits 31 to 1. Fast status bit 0, which marks the fast-request source, never raises it.
- R9: After reset both enable masks are 0 and both request outputs are low.
- R10: A source disabled on both levels shows in raw and raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | 31 | Level-sensitive request lines, bit n is source n |
| bus_addr_i | input | 3 | Register word address |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the addressed register |
| nreq_o | output | 1 | Normal interrupt request |
| freq_o | output | 1 | Fast interrupt request |

## Verification
A corrupted enable bit shows up in the enable and status reads at once. It shows on a request output one edge later, as a request that fires for a masked source or stays silent for an enabled one. A failure of the cross-level clear leaves the same bit readable as 1 on both levels right after the write. A wrong bit range in the fast OR shows only when the fast-request source position alone is active and enabled.

// File: rtl/dlic_pkg.sv
package dlic_pkg;
  localparam int unsigned W = 32;

  typedef enum logic [1:0] {
    OFS_RAW  = 2'd0,
    OFS_EN   = 2'd1,
    OFS_CLR  = 2'd2,
    OFS_STAT = 2'd3
  } reg_ofs_e;

  // Bits that software may set in an enable mask.
  function automatic logic [W-1:0] writable_mask(input int unsigned nsrc,
                                                 input int unsigned swi_bit);
    logic [W-1:0] m;
    for (int i = 0; i < W; i++) begin
      m[i] = (i < nsrc) && (i != swi_bit);
    end
    return m;
  endfunction

  function automatic logic [W-1:0] masked_status(input logic [W-1:0] raw,
                                                 input logic [W-1:0] en);
    return raw & en;
  endfunction

  // OR of bits lo and upward.
  function automatic logic any_from(input logic [W-1:0] v, input int unsigned lo);
    logic r;
    r = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (i >= lo) r = r | v[i];
    end
    return r;
  endfunction

  // Next enable value: own clear and cross clear drop bits, set wins.
  function automatic logic [W-1:0] enable_next(input logic [W-1:0] cur,
                                               input logic [W-1:0] set,
                                               input logic [W-1:0] clr,
                                               input logic [W-1:0] xclr);
    return (cur & ~clr & ~xclr) | set;
  endfunction
endpackage

// File: rtl/dlic_src_stage.sv
module dlic_src_stage
  import dlic_pkg::*;
#(
  parameter int unsigned NSRC = 31
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] src_i,
  output logic [W-1:0]    raw_o
);
  localparam int unsigned PAD = W - NSRC;

  logic [NSRC-1:0] raw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) raw_q <= '0;
    else         raw_q <= src_i;
  end

  generate
    if (PAD > 0) begin : g_pad
      assign raw_o = {{PAD{1'b0}}, raw_q};
    end else begin : g_nopad
      assign raw_o = raw_q;
    end
  endgenerate
endmodule

// File: rtl/dlic_enable_reg.sv
module dlic_enable_reg
  import dlic_pkg::*;
#(
  parameter logic [W-1:0] WMASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] xclr_i,
  output logic [W-1:0] en_o
);
  logic [W-1:0] en_q;
  logic [W-1:0] en_d;

  always_comb begin
    en_d = enable_next(en_q, set_i & WMASK, clr_i & WMASK, xclr_i & WMASK);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else         en_q <= en_d;
  end

  assign en_o = en_q;
endmodule

// File: rtl/dlic_req_gen.sv
module dlic_req_gen
  import dlic_pkg::*;
#(
  parameter int unsigned LO = 0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] raw_i,
  input  logic [W-1:0] en_i,
  output logic [W-1:0] stat_o,
  output logic         req_o
);
  logic req_q;

  assign stat_o = masked_status(raw_i, en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= any_from(stat_o, LO);
  end

  assign req_o = req_q;
endmodule

// File: rtl/dual_level_intc.sv
module dual_level_intc
  import dlic_pkg::*;
#(
  parameter int unsigned NSRC     = 31,
  parameter int unsigned SWI_BIT  = 1,
  parameter int unsigned FAST_BIT = 0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] src_i,
  input  logic [2:0]      bus_addr_i,
  input  logic            bus_we_i,
  input  logic [W-1:0]    bus_wdata_i,
  output logic [W-1:0]    bus_rdata_o,
  output logic            nreq_o,
  output logic            freq_o
);
  localparam logic [W-1:0] WMASK = writable_mask(NSRC, SWI_BIT);
  localparam int unsigned NLVL = 2;

  logic [W-1:0] raw_w;
  logic [W-1:0] set_w  [NLVL];
  logic [W-1:0] clr_w  [NLVL];
  logic [W-1:0] en_w   [NLVL];
  logic [W-1:0] stat_w [NLVL];
  logic         req_w  [NLVL];
  logic [W-1:0] n_en_w;
  logic [W-1:0] f_en_w;
  reg_ofs_e     ofs;

  assign ofs = reg_ofs_e'(bus_addr_i[1:0]);

  dlic_src_stage #(.NSRC(NSRC)) u_src (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .src_i (src_i),
    .raw_o (raw_w)
  );

  for (genvar l = 0; l < NLVL; l++) begin : g_lvl
    localparam logic LV = 1'(l);
    localparam int unsigned LO = (l == 1) ? FAST_BIT + 1 : 0;
    logic hit;

    assign hit      = bus_we_i && (bus_addr_i[2] == LV);
    assign set_w[l] = (hit && ofs == OFS_EN)  ? bus_wdata_i : '0;
    assign clr_w[l] = (hit && ofs == OFS_CLR) ? bus_wdata_i : '0;

    dlic_enable_reg #(.WMASK(WMASK)) u_en (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (set_w[l]),
      .clr_i (clr_w[l]),
      .xclr_i(set_w[NLVL-1-l]),
      .en_o  (en_w[l])
    );

    dlic_req_gen #(.LO(LO)) u_req (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .raw_i (raw_w),
      .en_i  (en_w[l]),
      .stat_o(stat_w[l]),
      .req_o (req_w[l])
    );
  end

  assign n_en_w = en_w[0];
  assign f_en_w = en_w[1];
  assign nreq_o = req_w[0];
  assign freq_o = req_w[1];

  always_comb begin
    bus_rdata_o = '0;
    unique case (ofs)
      OFS_RAW:  bus_rdata_o = raw_w;
      OFS_EN:   bus_rdata_o = bus_addr_i[2] ? en_w[1] : en_w[0];
      OFS_CLR:  bus_rdata_o = '0;
      OFS_STAT: bus_rdata_o = bus_addr_i[2] ? stat_w[1] : stat_w[0];
      default:  bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/dlic_sva.sv
module dlic_sva
  import dlic_pkg::*;
#(
  parameter logic [W-1:0] WMASK = writable_mask(31, 1)
) (
  input logic         clk,
  input logic         rst_n,
  input logic         we,
  input logic [2:0]   addr,
  input logic [W-1:0] wdata,
  input logic [W-1:0] n_en,
  input logic [W-1:0] f_en,
  input logic [W-1:0] raw,
  input logic         nreq,
  input logic         freq
);
  a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (n_en & f_en) == '0);

  a_r5_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
    ((n_en | f_en) & ~WMASK) == '0);

  a_r2_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == 3'd1) |=>
      ((n_en & $past(wdata & WMASK)) == $past(wdata & WMASK)));

  a_r3_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == 3'd6) |=> ((f_en & $past(wdata & WMASK)) == '0));

  a_r7_normal_req: assert property (@(posedge clk) disable iff (!rst_n)
    nreq == $past(|(raw & n_en)));

  a_r8_fast_req: assert property (@(posedge clk) disable iff (!rst_n)
    freq == $past(|(raw[W-1:1] & f_en[W-1:1])));
endmodule

bind dual_level_intc dlic_sva #(.WMASK(WMASK)) u_sva (
  .clk  (clk_i),
  .rst_n(rst_ni),
  .we   (bus_we_i),
  .addr (bus_addr_i),
  .wdata(bus_wdata_i),
  .n_en (n_en_w),
  .f_en (f_en_w),
  .raw  (raw_w),
  .nreq (nreq_o),
  .freq (freq_o)
);

// File: tb/dual_level_intc_tb.sv
`timescale 1ns/1ps
module dual_level_intc_tb;
  localparam logic [31:0] WM = 32'h7FFF_FFFD;
  localparam logic [2:0] N_RAW = 3'd0, N_EN = 3'd1, N_CLR = 3'd2, N_ST = 3'd3;
  localparam logic [2:0] F_RAW = 3'd4, F_EN = 3'd5, F_CLR = 3'd6, F_ST = 3'd7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [30:0] src = '0;
  logic [2:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        nreq, freq;

  int checks = 0;
  int errors = 0;
  logic [31:0] n_m = '0;
  logic [31:0] f_m = '0;

  always #2.5 clk = ~clk;

  dual_level_intc u_dut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .bus_addr_i(addr),
    .bus_we_i(we), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .nreq_o(nreq), .freq_o(freq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
    case (a)
      N_EN:  begin n_m = n_m | (d & WM); f_m = f_m & ~(d & WM); end
      F_EN:  begin f_m = f_m | (d & WM); n_m = n_m & ~(d & WM); end
      N_CLR: n_m = n_m & ~(d & WM);
      F_CLR: f_m = f_m & ~(d & WM);
      default: ;
    endcase
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic set_src(input logic [30:0] s);
    @(negedge clk);
    src = s;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic clear_all();
    wr(N_CLR, 32'hFFFF_FFFF);
    wr(F_CLR, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R9 nreq after reset", {31'b0, nreq}, 32'd0);
    chk("R9 freq after reset", {31'b0, freq}, 32'd0);
    rd(N_EN, d); chk("R9 normal enable reset", d, 32'd0);
    rd(F_EN, d); chk("R9 fast enable reset", d, 32'd0);
  endtask

  task automatic t_raw();
    logic [31:0] d;
    set_src(31'h5A5A_1234);
    rd(N_RAW, d); chk("R1 raw normal view", d, 32'h5A5A_1234);
    rd(F_RAW, d); chk("R1 raw fast view", d, 32'h5A5A_1234);
    wr(N_RAW, 32'hFFFF_FFFF);
    rd(N_RAW, d); chk("R1 raw ignores write", d, 32'h5A5A_1234);
    set_src(31'h7FFF_FFFF);
    rd(F_RAW, d); chk("R1 raw bit31 zero", d, 32'h7FFF_FFFF);
    set_src('0);
  endtask

  task automatic t_set_clear();
    logic [31:0] d;
    wr(N_EN, 32'h0000_00F0);
    rd(N_EN, d); chk("R2 set bits", d, n_m);
    wr(N_EN, 32'h0000_0F00);
    rd(N_EN, d); chk("R2 zero keeps bits", d, 32'h0000_0FF0);
    wr(N_CLR, 32'h0000_0030);
    rd(N_EN, d); chk("R3 clear selected bits", d, 32'h0000_0FC0);
    rd(N_CLR, d); chk("R3 clear reads zero", d, 32'd0);
  endtask

  task automatic t_exclusive();
    logic [31:0] d;
    wr(F_EN, 32'h0000_00C0);
    rd(F_EN, d); chk("R4 fast set", d, 32'h0000_00C0);
    rd(N_EN, d); chk("R4 normal cross-cleared", d, 32'h0000_0F00);
    wr(N_EN, 32'h0000_0040);
    rd(N_EN, d); chk("R4 normal set back", d, 32'h0000_0F40);
    rd(F_EN, d); chk("R4 fast cross-cleared", d, 32'h0000_0080);
    clear_all();
  endtask

  task automatic t_fixed_bits();
    logic [31:0] d;
    wr(N_EN, 32'hFFFF_FFFF);
    rd(N_EN, d); chk("R5 normal swi and bit31", d, 32'h7FFF_FFFD);
    wr(F_EN, 32'hFFFF_FFFF);
    rd(F_EN, d); chk("R5 fast swi and bit31", d, 32'h7FFF_FFFD);
    rd(N_EN, d); chk("R5 normal after fast all", d, n_m);
    clear_all();
  endtask

  task automatic t_status();
    logic [31:0] d;
    wr(N_EN, 32'h0000_F0F0);
    wr(F_EN, 32'h00FF_0000);
    set_src(31'h0F0F_3C3C);
    rd(N_ST, d); chk("R6 normal status", d, 32'h0F0F_3C3C & n_m);
    rd(F_ST, d); chk("R6 fast status", d, 32'h0F0F_3C3C & f_m);
    chk("R7 normal req from status", {31'b0, nreq}, 32'd1);
    chk("R8 fast req from status", {31'b0, freq}, 32'd1);
    set_src('0);
    clear_all();
  endtask

  task automatic t_latency();
    wr(N_EN, 32'h0000_0020);
    @(negedge clk);
    src = 31'h0000_0020;
    @(negedge clk);
    chk("R7 req not after one edge", {31'b0, nreq}, 32'd0);
    @(negedge clk);
    chk("R7 req after two edges", {31'b0, nreq}, 32'd1);
    wr(N_CLR, 32'h0000_0020);
    @(negedge clk);
    chk("R7 req drops after clear", {31'b0, nreq}, 32'd0);
    set_src('0);
    clear_all();
  endtask

  task automatic t_fast_bit0();
    logic [31:0] d;
    wr(F_EN, 32'h0000_0001);
    set_src(31'h0000_0001);
    rd(F_ST, d); chk("R8 fast status bit0", d, 32'h0000_0001);
    chk("R8 fast bit0 no request", {31'b0, freq}, 32'd0);
    wr(N_EN, 32'h0000_0001);
    @(negedge clk);
    chk("R7 normal bit0 requests", {31'b0, nreq}, 32'd1);
    chk("R8 fast off after move", {31'b0, freq}, 32'd0);
    clear_all();
    wr(F_EN, 32'h4000_0000);
    set_src(31'h4000_0000);
    chk("R8 fast bit30 requests", {31'b0, freq}, 32'd1);
    set_src('0);
    clear_all();
  endtask

  task automatic t_both_off();
    logic [31:0] d;
    wr(N_EN, 32'h0000_0100);
    wr(F_EN, 32'h0000_0100);
    wr(F_CLR, 32'h0000_0100);
    set_src(31'h7FFF_FFFF);
    rd(N_RAW, d); chk("R10 raw visible", d, 32'h7FFF_FFFF);
    rd(N_EN, d); chk("R10 normal disabled", d, 32'd0);
    rd(F_EN, d); chk("R10 fast disabled", d, 32'd0);
    chk("R10 no normal req", {31'b0, nreq}, 32'd0);
    chk("R10 no fast req", {31'b0, freq}, 32'd0);
    set_src('0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_raw();
    t_set_clear();
    t_exclusive();
    t_fixed_bits();
    t_status();
    t_latency();
    t_fast_bit0();
    t_both_off();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule